// File: doc/BRIEF.md
# Soft-Start Reference Staircase Generator

This block produces the digital code that feeds the reference DAC of a switching regulator's error amplifier during start-up. After the converter leaves lockout, the code climbs from zero to its full-scale value of 127 as a staircase of 127 equal increments. Each increment corresponds to roughly 9.7 mV of reference, so code 127 stands for the full 1.23 V reference. The length of the ramp is set by a count of oscillator cycles and not by any analog time constant. The whole climb takes exactly 2047 oscillator ticks.

The block runs on the system clock. It advances only on cycles where the oscillator tick strobe is high. Every step from code 0 up to code 126 lasts 16 ticks. The last step, from 126 to 127, lasts 31 ticks and absorbs the remainder, so the total comes to 2047. A restart request clears the ramp back to zero, and the surrounding control logic issues one after every shutdown or fault recovery. A hold-at-zero input keeps the ramp parked at zero for as long as lockout lasts. Once the code reaches full scale, a done flag rises and the code stays at 127.

Top module: `softstart_ref_stepper`

## Requirements
- R1: While reset is asserted and immediately after it, `ref_code` is 0 and `ramp_done` is 0.
- R2: For codes 0 through 125, `ref_code` goes up by exactly one on the clock edge that samples the 16th accepted `osc_tick` at the current code, and at no other edge.
- R3: The step from code 126 to 127 takes 31 accepted ticks. Starting from a cleared state, code 127 is reached on the edge that samples exactly the 2047th accepted tick.
- R4: `ramp_done` is 1 exactly when `ref_code` equals 127, and it stays 1 until a restart request or hold is applied.
- R5: Ticks that arrive while `ramp_done` is 1 have no effect: `ref_code` stays at 127.
- R6: `restart_req` high at a clock edge sets `ref_code` to 0, clears `ramp_done`, and discards any partial step count. The following ramp again needs 16 ticks for its first step and 2047 ticks in total.
- R7: While `hold_zero` is high, `ref_code` is 0 and `ramp_done` is 0 from the next edge on, and ticks are ignored. The ramp starts from the beginning after `hold_zero` falls.
- R8: Outside of a clear, `ref_code` never decreases and changes by at most one per clock.
- R9: On a clock edge where `osc_tick` is low and no clear is applied, `ref_code` and `ramp_done` keep their values.
- R10: A restart request or hold wins over a tick in the same cycle: the result is code 0, with no step counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| restart_req | input | 1 | Restart the ramp from code 0 on the next edge |
| hold_zero | input | 1 | Keep the ramp at zero while high |
| ref_code | output | 7 | Reference staircase code, 0 to 127 |
| ramp_done | output | 1 | High once the code has reached full scale |

## Verification
The bench counts ticks across complete ramps and compares the codes at the boundaries against values it computes itself: code 1 after tick 16, code 126 after tick 2016, still 126 after tick 2046, and 127 after tick 2047. A design with the wrong dwell length, or with the remainder placed on the wrong step, shows the wrong code at one of these points. It also applies restart requests in the middle of a ramp, together with a tick in the same cycle. A design that kept the partial step count would take its next step too early, and one that let the tick win would leave a nonzero code. Random ticks, holds and restarts are checked cycle by cycle against a bench model. These runs catch a design that moves without a tick, keeps stepping past 127, or lets the done flag drift away from full scale.

// File: rtl/ss_pkg.sv
package ss_pkg;

  // Base dwell per step: integer share of the tick budget.
  function automatic int unsigned base_dwell(input int unsigned steps,
                                             input int unsigned ticks);
    return ticks / steps;
  endfunction

  // Dwell of the last step: base dwell plus the leftover ticks.
  function automatic int unsigned last_dwell(input int unsigned steps,
                                             input int unsigned ticks);
    return (ticks / steps) + (ticks - (ticks / steps) * steps);
  endfunction

endpackage

// File: rtl/ss_dwell_timer.sv
module ss_dwell_timer #(
  parameter int unsigned DWELL       = 16,
  parameter int unsigned FINAL_DWELL = 31,
  localparam int unsigned DW         = $clog2(FINAL_DWELL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv_en,
  input  logic last_step,
  output logic step_o
);

  localparam logic [DW-1:0] LIM_BASE = DW'(DWELL - 1);
  localparam logic [DW-1:0] LIM_LAST = DW'(FINAL_DWELL - 1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [DW-1:0] limit;
  logic          at_limit;

  always_comb begin
    limit    = last_step ? LIM_LAST : LIM_BASE;
    at_limit = (cnt_q == limit);
    step_o   = adv_en && !clr && at_limit;
    cnt_en   = clr || adv_en;
    if (clr)           cnt_d = '0;
    else if (at_limit) cnt_d = '0;
    else               cnt_d = cnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ss_code_track.sv
module ss_code_track #(
  parameter int unsigned STEPS   = 127,
  localparam int unsigned CODE_W = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step_i,
  output logic [CODE_W-1:0] code_o,
  output logic              last_o,
  output logic              done_o
);

  localparam logic [CODE_W-1:0] CODE_TOP  = CODE_W'(STEPS);
  localparam logic [CODE_W-1:0] CODE_LAST = CODE_W'(STEPS - 1);

  logic [CODE_W-1:0] code_q, code_d;
  logic              done_q, done_d;
  logic              upd_en;

  always_comb begin
    upd_en = clr || step_i;
    if (clr) begin
      code_d = '0;
      done_d = 1'b0;
    end else begin
      code_d = code_q + CODE_W'(1);
      done_d = (code_d == CODE_TOP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      done_q <= 1'b0;
    end else if (upd_en) begin
      code_q <= code_d;
      done_q <= done_d;
    end
  end

  assign code_o = code_q;
  assign done_o = done_q;
  assign last_o = (code_q == CODE_LAST);

endmodule

// File: rtl/softstart_ref_stepper.sv
module softstart_ref_stepper #(
  parameter int unsigned STEPS      = 127,
  parameter int unsigned RAMP_TICKS = 2047,
  localparam int unsigned CODE_W    = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              restart_req,
  input  logic              hold_zero,
  output logic [CODE_W-1:0] ref_code,
  output logic              ramp_done
);

  import ss_pkg::*;

  localparam int unsigned DWELL_N = base_dwell(STEPS, RAMP_TICKS);
  localparam int unsigned DWELL_F = last_dwell(STEPS, RAMP_TICKS);

  logic clr;
  logic adv_en;
  logic step;
  logic last_step;
  logic done;

  assign clr    = restart_req || hold_zero;
  assign adv_en = osc_tick && !done;

  ss_dwell_timer #(
    .DWELL      (DWELL_N),
    .FINAL_DWELL(DWELL_F)
  ) i_dwell (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .adv_en   (adv_en),
    .last_step(last_step),
    .step_o   (step)
  );

  ss_code_track #(
    .STEPS(STEPS)
  ) i_code (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .step_i(step),
    .code_o(ref_code),
    .last_o(last_step),
    .done_o(done)
  );

  assign ramp_done = done;

endmodule

// File: rtl/softstart_ref_stepper_chk.sv
module softstart_ref_stepper_chk #(
  parameter int unsigned STEPS      = 127,
  parameter int unsigned RAMP_TICKS = 2047,
  localparam int unsigned CODE_W    = $clog2(STEPS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              osc_tick,
  input logic              restart_req,
  input logic              hold_zero,
  input logic [CODE_W-1:0] ref_code,
  input logic              ramp_done
);

  localparam int unsigned DW_N = RAMP_TICKS / STEPS;
  localparam int unsigned DW_F = DW_N + (RAMP_TICKS - DW_N * STEPS);
  localparam int unsigned SW   = $clog2(DW_F + 1);

  logic          clr;
  logic [SW-1:0] seen_q;
  logic [SW-1:0] need;

  assign clr  = restart_req || hold_zero;
  assign need = (ref_code == CODE_W'(STEPS - 1)) ? SW'(DW_F) : SW'(DW_N);

  // Independent count of ticks spent at the present code.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          seen_q <= '0;
    else if (clr)                        seen_q <= '0;
    else if (osc_tick && !ramp_done) begin
      if (seen_q + SW'(1) == need)       seen_q <= '0;
      else                               seen_q <= seen_q + SW'(1);
    end
  end

  // R4
  p_done_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done == (ref_code == CODE_W'(STEPS)));

  p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_done && !clr) |=> ramp_done);

  p_done_ignores_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_done && !clr) |=> $stable(ref_code));

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> (ref_code == '0 && !ramp_done));

  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_zero |=> (ref_code == '0 && !ramp_done));

  p_monotonic_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (ref_code == $past(ref_code) || ref_code == $past(ref_code) + CODE_W'(1)));

  p_no_tick_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_tick && !clr) |=> ($stable(ref_code) && $stable(ramp_done)));

  p_early_tick_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_tick && !clr && !ramp_done && (seen_q + SW'(1) != need)) |=> $stable(ref_code));

  p_step_on_dwell_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_tick && !clr && !ramp_done && (seen_q + SW'(1) == need))
      |=> ref_code == $past(ref_code) + CODE_W'(1));

endmodule

bind softstart_ref_stepper softstart_ref_stepper_chk #(
  .STEPS     (STEPS),
  .RAMP_TICKS(RAMP_TICKS)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .osc_tick   (osc_tick),
  .restart_req(restart_req),
  .hold_zero  (hold_zero),
  .ref_code   (ref_code),
  .ramp_done  (ramp_done)
);

// File: tb/test_softstart_ref_stepper.sv
module test_softstart_ref_stepper;

  localparam int STEPS = 127;
  localparam int TOTAL = 2047;
  localparam int DW_N  = TOTAL / STEPS;
  localparam int DW_F  = DW_N + (TOTAL - DW_N * STEPS);

  logic       clk;
  logic       rst_n;
  logic       osc_tick;
  logic       restart_req;
  logic       hold_zero;
  logic [6:0] ref_code;
  logic       ramp_done;

  int total_chk;
  int bad_chk;
  int m_code;
  int m_cnt;
  bit m_done;
  bit finished;

  softstart_ref_stepper i_softstart_ref_stepper (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_tick   (osc_tick),
    .restart_req(restart_req),
    .hold_zero  (hold_zero),
    .ref_code   (ref_code),
    .ramp_done  (ramp_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int dwell_for(input int code);
    return (code == STEPS - 1) ? DW_F : DW_N;
  endfunction

  // Reference model, written from the requirements.
  task automatic model_edge(input bit tk, input bit rs, input bit hz);
    if (rs || hz) begin
      m_code = 0; m_cnt = 0; m_done = 0;
    end else if (tk && !m_done) begin
      if (m_cnt + 1 == dwell_for(m_code)) begin
        m_cnt  = 0;
        m_code = m_code + 1;
        m_done = (m_code == STEPS);
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    total_chk++;
    if (act != exp) begin
      bad_chk++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive after the falling edge, compare after the rising edge.
  task automatic cyc(input bit tk, input bit rs, input bit hz, input string req);
    @(negedge clk);
    osc_tick = tk; restart_req = rs; hold_zero = hz;
    @(posedge clk);
    model_edge(tk, rs, hz);
    #2;
    check(req, ref_code, m_code);
    check(req, ramp_done, m_done);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2047));
    total_chk = 0; bad_chk = 0; finished = 0;
    m_code = 0; m_cnt = 0; m_done = 0;
    osc_tick = 0; restart_req = 0; hold_zero = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset code", ref_code, 0);
    check("R1 reset done", ramp_done, 0);
    @(negedge clk);
    rst_n = 1;
    cyc(0, 0, 0, "R1 after reset");

    // Full ramp with a tick on every cycle, boundary checks.
    for (int t = 1; t <= TOTAL; t++) begin
      cyc(1, 0, 0, "R2 ramp");
      if (t == 15)   check("R2 tick15", ref_code, 0);
      if (t == 16)   check("R2 tick16", ref_code, 1);
      if (t == 2016) check("R3 tick2016", ref_code, 126);
      if (t == 2046) check("R3 tick2046", ref_code, 126);
      if (t == 2046) check("R4 not done before end", ramp_done, 0);
      if (t == 2047) check("R3 tick2047", ref_code, 127);
      if (t == 2047) check("R4 done at end", ramp_done, 1);
    end
    for (int i = 0; i < 40; i++) cyc(1, 0, 0, "R5 ticks after done");
    check("R5 code held at full scale", ref_code, 127);

    // Idle cycles with no tick.
    cyc(0, 0, 0, "R9 idle");
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, "R9 prep");
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, "R9 idle");

    // Restart together with a tick, in the middle of a ramp.
    cyc(1, 1, 0, "R10 restart beats tick");
    check("R6 restart clears code", ref_code, 0);
    for (int t = 1; t <= 100; t++) cyc(1, 0, 0, "R6 partial ramp");
    check("R6 partial code", ref_code, 100 / DW_N);
    cyc(1, 1, 0, "R6 mid restart");
    for (int t = 1; t <= 15; t++) cyc(1, 0, 0, "R6 no early step");
    check("R6 partial count discarded", ref_code, 0);
    cyc(1, 0, 0, "R6 first step");
    check("R6 first step after restart", ref_code, 1);

    // Hold at zero while ticks keep arriving.
    for (int i = 0; i < 30; i++) cyc(1, 0, 1, "R7 hold");
    check("R7 held code", ref_code, 0);
    check("R7 held done", ramp_done, 0);
    begin
      int n;
      n = 0;
      while (!ramp_done && n < 5000) begin
        cyc(1, 0, 0, "R3 second ramp");
        n++;
      end
      check("R3 ticks to done after hold", n, TOTAL);
    end

    // Random mix of ticks, restarts and holds.
    for (int i = 0; i < 30000; i++) begin
      bit tk, rs, hz;
      tk = ($urandom % 4) != 0;
      rs = ($urandom % 4000) == 0;
      hz = ($urandom % 5000) == 0;
      cyc(tk, rs, hz, "R8 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

endmodule